// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives a 16x oversampling tick for a serial receiver and transmitter from the system clock. A plain integer divider can only reach bit rates that divide the clock exactly. Here an integer divisor sets the base length of each oversample period, and a 16-bit slot mask adds one extra clock to selected periods. Across one 16-period cycle the average period is therefore `divisor + 1 + ones(mask)/16` clocks, a fractional value.

The effective divide value is `f_clk / (16 * bit_rate) - 1`. Its integer part goes into the divisor. Its fractional part, times 16 and rounded, is the number of ones to place in the mask. Two examples: a 40 MHz clock at 115200 bit/s gives 20.7, so the divisor is 20 and the mask has 11 ones. A 66.5 MHz clock at the same rate gives divisor 35 and a mask with one bit set. Spreading the ones evenly across the mask keeps the jitter of each period within one clock.

The enable input starts and stops the generator. While it is low, all state is held at zero. The current slot index is exposed on a port for observation. The divisor and the mask should be changed only while the block is disabled.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and until the enable is first raised after reset, `tick_o` is 0 and `slot_o` is 0.
- R2: While `en_i` is low, `tick_o` stays 0. From the first clock edge with `en_i` low, `slot_o` reads 0.
- R3: An oversample period whose mask bit is 0 lasts exactly `div_i + 1` clock cycles. It ends with a one-cycle `tick_o` pulse in its last cycle.
- R4: An oversample period whose mask bit is 1 lasts exactly `div_i + 2` clock cycles.
- R5: `slot_o` advances by one after each tick and wraps from 15 to 0. Period k of a cycle is governed by bit k of `slot_mask_i`, where bit 0 is the least significant bit. During the tick of period k, `slot_o` equals k.
- R6: Any 16 consecutive periods starting at slot 0 last `16 * (div_i + 1) + ones(slot_mask_i)` cycles in total.
- R7: After `en_i` rises, the first period is timed from the first cycle in which `en_i` is high, that cycle included. The first period uses mask bit 0, even if the generator was stopped in the middle of a cycle.
- R8: With `div_i = 0` and `slot_mask_i = 0`, `tick_o` is high in every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| en_i | input | 1 | Run enable; low clears and holds the counter and the slot index |
| div_i | input | 16 | Integer part of the divide value |
| slot_mask_i | input | 16 | One bit per slot; a set bit stretches that period by one clock |
| tick_o | output | 1 | One-cycle pulse marking the last cycle of each oversample period |
| slot_o | output | 4 | Index of the period currently being timed |

## Verification
A counter that misses its terminal value shows up at once: the tick arrives late or is missing. A wrong limit makes the first period too short or too long by a visible amount. A slot index that steps wrongly or fails to wrap shows in the value of `slot_o` at the next tick. It also makes the wrong mask bit stretch a period, so the period lengths differ from the mask within one cycle of 16 ticks. State that survives a disable shows in the first period after re-enable, which must use mask bit 0 and have its full length.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  // Default width of the integer divisor.
  localparam int unsigned FBG_DIV_W = 16;

  // Oversample periods per mask cycle (16x oversampling).
  localparam int unsigned FBG_SLOTS = 16;

  // Reset synchroniser depth.
  localparam int unsigned FBG_SYNC_STAGES = 2;

endpackage

// File: rtl/fbg_rst_sync.sv
module fbg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt #(
  parameter  int unsigned DIV_W = 16,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             stretch_i,
  output logic             term_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;
  logic             at_limit;

  // The last count of a period is div, or div+1 when the slot is stretched.
  always_comb begin
    limit    = {1'b0, div_i} + CNT_W'(stretch_i);
    at_limit = (cnt_q == limit);
    term_o   = run_i & at_limit;
  end

  always_comb begin
    if (!run_i) begin
      cnt_d = '0;
    end else if (at_limit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fbg_slot_seq.sv
module fbg_slot_seq #(
  parameter  int unsigned SLOTS  = 16,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              adv_i,
  input  logic [SLOTS-1:0]  mask_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              stretch_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;
  logic [SLOTS-1:0]  slot_hot;

  // One-hot decode of the current slot, one lane per mask bit.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot_dec
    assign slot_hot[g] = (slot_q == SLOT_W'(g));
  end

  assign stretch_o = |(slot_hot & mask_i);

  always_comb begin
    if (!run_i) begin
      slot_d = '0;
    end else if (adv_i) begin
      slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + SLOT_W'(1);
    end else begin
      slot_d = slot_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_d;
    end
  end

  assign slot_o = slot_q;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter  int unsigned DIV_W  = frac_baud_pkg::FBG_DIV_W,
  parameter  int unsigned SLOTS  = frac_baud_pkg::FBG_SLOTS,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [SLOTS-1:0]  slot_mask_i,
  output logic              tick_o,
  output logic [SLOT_W-1:0] slot_o
);

  logic rst_n_sync;
  logic run;
  logic stretch;
  logic term;

  fbg_rst_sync #(
    .STAGES (frac_baud_pkg::FBG_SYNC_STAGES)
  ) i_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_sync)
  );

  // No ticks while the internal reset is still held.
  assign run = en_i & rst_n_sync;

  fbg_slot_seq #(
    .SLOTS (SLOTS)
  ) i_slot_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .run_i     (run),
    .adv_i     (term),
    .mask_i    (slot_mask_i),
    .slot_o    (slot_o),
    .stretch_o (stretch)
  );

  fbg_period_cnt #(
    .DIV_W (DIV_W)
  ) i_period_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .run_i     (run),
    .div_i     (div_i),
    .stretch_i (stretch),
    .term_o    (term)
  );

  assign tick_o = term;

endmodule

// File: rtl/fbg_chk.sv
module fbg_chk #(
  parameter  int unsigned DIV_W  = 16,
  parameter  int unsigned SLOTS  = 16,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [DIV_W-1:0]  div_i,
  input logic [SLOTS-1:0]  slot_mask_i,
  input logic              tick_o,
  input logic [SLOT_W-1:0] slot_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_nxt;
  logic [DIV_W+1:0]  gap_q;
  logic [DIV_W+1:0]  want_gap;

  assign slot_nxt = (slot_o == LAST_SLOT) ? '0 : slot_o + SLOT_W'(1);
  assign want_gap = (DIV_W+2)'(div_i) + (DIV_W+2)'(slot_mask_i[slot_o]);

  // Cycles elapsed in the current period before this one.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
    end else if (!en_i || tick_o) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + (DIV_W+2)'(1);
    end
  end

  // R2
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);

  // R2
  idle_slot_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (slot_o == '0));

  // R5
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_o) |=> (!en_i || slot_o == $past(slot_nxt)));

  // R5
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_o) |=> (!en_i || $stable(slot_o)));

  // R3 R4
  period_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (gap_q == want_gap));

endmodule

bind frac_baud_gen fbg_chk #(
  .DIV_W (DIV_W),
  .SLOTS (SLOTS)
) i_fbg_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_n_sync),
  .en_i        (en_i),
  .div_i       (div_i),
  .slot_mask_i (slot_mask_i),
  .tick_o      (tick_o),
  .slot_o      (slot_o)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;

  localparam int NVEC = 6;
  localparam logic [15:0] VDIV  [NVEC] = '{16'd20, 16'd35, 16'd0, 16'd0, 16'd3, 16'd7};
  localparam logic [15:0] VMASK [NVEC] = '{16'hDB6D, 16'h0001, 16'h0000, 16'hFFFF, 16'h8001, 16'hAAAA};

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [15:0] div_r;
  logic [15:0] mask_r;
  logic        tick;
  logic [3:0]  slot;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  frac_baud_gen i_frac_baud_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .div_i       (div_r),
    .slot_mask_i (mask_r),
    .tick_o      (tick),
    .slot_o      (slot)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Wait for the next tick (at most limit cycles); returns cycles counted, tick cycle included.
  task automatic wait_tick(input int limit, output int cyc, output bit got);
    cyc = 0;
    got = 0;
    while (!got && cyc < limit) begin
      #1;
      cyc++;
      if (tick) got = 1;
      @(negedge clk);
    end
  endtask

  task automatic run_vector(input logic [15:0] d, input logic [15:0] m, input string tag);
    int total = 0;
    @(negedge clk);
    en = 1'b0; div_r = d; mask_r = m;
    @(negedge clk);
    en = 1'b1;
    for (int k = 0; k < 16; k++) begin
      int  cyc;
      bit  got;
      int  exp_len;
      int  slot_at;
      exp_len = int'(d) + 1 + int'(m[k]);
      cyc = 0; got = 0; slot_at = -1;
      while (!got && cyc < 70000) begin
        #1;
        cyc++;
        if (tick) begin got = 1; slot_at = int'(slot); end
        @(negedge clk);
      end
      total += cyc;
      if (m[k]) check(cyc == exp_len, {"R4 stretched period ", tag}, cyc, exp_len);
      else      check(cyc == exp_len, {"R3 plain period ", tag}, cyc, exp_len);
      check(slot_at == k, {"R5 slot at tick ", tag}, slot_at, k);
    end
    #1;
    check(slot == 4'd0, {"R5 wrap to 0 ", tag}, int'(slot), 0);
    check(total == 16 * (int'(d) + 1) + $countones(m), {"R6 cycle total ", tag},
          total, 16 * (int'(d) + 1) + $countones(m));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; div_r = 16'd0; mask_r = 16'd0;
    repeat (3) @(negedge clk);
    #1;
    check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    check(slot == 4'd0, "R1 slot in reset", int'(slot), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(tick == 1'b0 && slot == 4'd0, "R1 idle after reset", int'({tick, slot}), 0);

    // Table of vectors (R3 R4 R5 R6; entry 2 covers R8).
    for (int v = 0; v < NVEC; v++) begin
      run_vector(VDIV[v], VMASK[v], $sformatf("vec%0d", v));
    end

    // R8: divisor 0, empty mask -> tick in every enabled cycle.
    @(negedge clk);
    en = 1'b0; div_r = 16'd0; mask_r = 16'd0;
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      #1;
      check(tick == 1'b1, "R8 tick every cycle", int'(tick), 1);
      @(negedge clk);
    end

    // R2: disabled with the shortest settings -> no tick, slot 0.
    en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      #1;
      check(tick == 1'b0, "R2 no tick while disabled", int'(tick), 0);
      check(slot == 4'd0, "R2 slot zero while disabled", int'(slot), 0);
      @(negedge clk);
    end

    // R7 / R2: stop mid cycle, restart uses bit 0 and a full first period.
    div_r = 16'd2; mask_r = 16'h0001;
    en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      int c; bit g;
      wait_tick(100, c, g);
      check(g, "R7 ticks before stop", int'(g), 1);
    end
    #1;
    check(slot == 4'd3, "R5 slot after three ticks", int'(slot), 3);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    #1;
    check(slot == 4'd0, "R2 slot cleared by disable", int'(slot), 0);
    @(negedge clk);
    en = 1'b1;
    begin
      int c; bit g;
      wait_tick(100, c, g);
      check(c == 4, "R7 first period after restart", c, 4);
      wait_tick(100, c, g);
      check(c == 3, "R7 second period after restart", c, 3);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule